// File: doc/BRIEF.md
# Timer Compare-Match Output Unit

This block keeps the compare output flip-flop of an 8-bit timer and steers one shared port pin. Each compare-match pulse, or a software force strobe, updates the flip-flop. The update is toggle, clear or set, and a two-bit mode field chooses which. The same field decides who owns the pin level. When the field is zero, the general port data bit drives the pin. When it is nonzero, the compare flip-flop drives it.

The pin's output enable always comes from the port's direction bit. Because of this, software can preload the compare state with a force strobe while the pin is still an input. The first level driven onto the pin is then already correct. The mode field is not double-buffered: a write is seen by the next clock edge. The counter, the comparator and the waveform generator are outside this block. A match pulse and a PWM-mode flag stand in for them.

Top module: `cmp_out_unit`

## Requirements
- R1: After reset the compare state is 0, the mode field is 00 (pin follows the port data bit), the match flag is 0 and the output enable equals the direction input.
- R2: With mode 01, a match inverts the compare state at the next clock edge.
- R3: With mode 10, a match clears the compare state. With mode 11, a match sets it.
- R4: With mode 00, a match leaves the compare state unchanged.
- R5: When the PWM flag is 0, a force strobe applies the current mode's action to the compare state at the next edge. It does not raise the match flag.
- R6: When the PWM flag is 1, a force strobe alone has no effect on the compare state.
- R7: If a force strobe and a match arrive in the same cycle, the action is applied once. With mode 01 the state toggles a single time.
- R8: When the mode field is nonzero, the pin value equals the compare state. When it is 00, the pin value equals the port data input.
- R9: The pin output enable always equals the direction input, whatever the mode.
- R10: A mode write takes effect at the clock edge that samples it. A match in the same cycle as the write uses the previous mode. A match in the next cycle uses the new mode.
- R11: The match flag is high for exactly the cycle after a cycle with the match input high, and only then.
- R12: Changing the PWM flag never alters the compare state.
- R13: The compare state can be preset by a force strobe while the direction input is 0. Once the direction input goes to 1, the pin shows that preset level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| match_i | input | 1 | Compare-match pulse from the comparator |
| force_i | input | 1 | Software force-compare strobe |
| pwm_mode_i | input | 1 | High while the waveform generator is in a PWM mode |
| cfg_wr_i | input | 1 | Write strobe for the mode field |
| cfg_mode_i | input | 2 | New mode value: 00 off, 01 toggle, 10 clear, 11 set |
| port_data_i | input | 1 | General port data bit for the pin |
| port_dir_i | input | 1 | Port direction bit, 1 = output |
| cmp_state_o | output | 1 | Internal compare output state |
| match_flag_o | output | 1 | Registered match flag |
| pin_o | output | 1 | Level presented to the pin |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
The bench builds the block with its default two-bit mode field. All four action codes are therefore reachable, including a mode change in the same cycle as a match. The bench switches the PWM flag and the direction bit around force strobes. This brings the preset-before-enable sequence and the ignored force in PWM mode within reach. It also drives force and match together, to expose a double application of the action.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        CMU_OFF    = 2'b00,
        CMU_TOGGLE = 2'b01,
        CMU_CLEAR  = 2'b10,
        CMU_SET    = 2'b11
    } cmu_mode_e;

    typedef struct packed {
        logic oc;
        logic flag;
    } cmu_oc_t;
endpackage

// File: rtl/cmu_mode_reg.sv
module cmu_mode_reg
    import cmu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_i,
    input  cmu_mode_e mode_i,
    output cmu_mode_e mode_o
);
    cmu_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (wr_i) mode_d = mode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= CMU_OFF;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q;

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mode_q == $past(mode_i))); // R10

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mode_q)); // R10
endmodule

// File: rtl/cmu_oc_ff.sv
module cmu_oc_ff
    import cmu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      match_i,
    input  logic      force_i,
    input  logic      pwm_i,
    input  cmu_mode_e mode_i,
    output logic      oc_o,
    output logic      flag_o
);
    cmu_oc_t st_d, st_q;
    logic    act;

    always_comb begin
        st_d = st_q;
        act  = match_i | (force_i & ~pwm_i);
        if (act) begin
            unique case (mode_i)
                CMU_TOGGLE: st_d.oc = ~st_q.oc;
                CMU_CLEAR:  st_d.oc = 1'b0;
                CMU_SET:    st_d.oc = 1'b1;
                default:    st_d.oc = st_q.oc;
            endcase
        end
        st_d.flag = match_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oc_o   = st_q.oc;
    assign flag_o = st_q.flag;

    AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && mode_i == CMU_TOGGLE) |=> (st_q.oc != $past(st_q.oc))); // R2

    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && mode_i == CMU_CLEAR) |=> !st_q.oc); // R3

    AST_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && mode_i == CMU_SET) |=> st_q.oc); // R3

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == CMU_OFF) |=> $stable(st_q.oc)); // R4

    AST_PWM_FORCE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i && pwm_i && !match_i) |=> $stable(st_q.oc)); // R6

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        force_i && !match_i |=> !st_q.flag); // R5
endmodule

// File: rtl/cmu_pin_mux.sv
module cmu_pin_mux
    import cmu_pkg::*;
(
    input  cmu_mode_e mode_i,
    input  logic      oc_i,
    input  logic      port_data_i,
    input  logic      port_dir_i,
    output logic      pin_o,
    output logic      pin_oe_o
);
    always_comb begin
        pin_o    = (mode_i != CMU_OFF) ? oc_i : port_data_i;
        pin_oe_o = port_dir_i;
    end
endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
    import cmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match_i,
    input  logic              force_i,
    input  logic              pwm_mode_i,
    input  logic              cfg_wr_i,
    input  logic [MODE_W-1:0] cfg_mode_i,
    input  logic              port_data_i,
    input  logic              port_dir_i,
    output logic              cmp_state_o,
    output logic              match_flag_o,
    output logic              pin_o,
    output logic              pin_oe_o
);
    cmu_mode_e mode_q;
    logic      oc_q;

    cmu_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (cfg_wr_i),
        .mode_i (cmu_mode_e'(cfg_mode_i)),
        .mode_o (mode_q)
    );

    cmu_oc_ff u_oc (
        .clk     (clk),
        .rst_n   (rst_n),
        .match_i (match_i),
        .force_i (force_i),
        .pwm_i   (pwm_mode_i),
        .mode_i  (mode_q),
        .oc_o    (oc_q),
        .flag_o  (match_flag_o)
    );

    cmu_pin_mux u_mux (
        .mode_i      (mode_q),
        .oc_i        (oc_q),
        .port_data_i (port_data_i),
        .port_dir_i  (port_dir_i),
        .pin_o       (pin_o),
        .pin_oe_o    (pin_oe_o)
    );

    assign cmp_state_o = oc_q;

    AST_PWM_SWITCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_i && !force_i) |=> $stable(cmp_state_o)); // R12

    AST_FLAG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> match_flag_o); // R11
endmodule

// File: tb/cmp_out_unit_bench.sv
module cmp_out_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic match_i = 0, force_i = 0, pwm_mode_i = 0, cfg_wr_i = 0;
    logic [1:0] cfg_mode_i = 2'b00;
    logic port_data_i = 0, port_dir_i = 0;
    logic cmp_state_o, match_flag_o, pin_o, pin_oe_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int   tag;
        logic st;
        logic pin;
        logic oe;
        logic flag;
    } exp_t;
    exp_t q[$];

    logic       st_m = 0;
    logic [1:0] mode_m = 2'b00;

    always #5 clk = ~clk;

    cmp_out_unit u_cmp_out_unit (
        .clk(clk), .rst_n(rst_n), .match_i(match_i), .force_i(force_i),
        .pwm_mode_i(pwm_mode_i), .cfg_wr_i(cfg_wr_i), .cfg_mode_i(cfg_mode_i),
        .port_data_i(port_data_i), .port_dir_i(port_dir_i),
        .cmp_state_o(cmp_state_o), .match_flag_o(match_flag_o),
        .pin_o(pin_o), .pin_oe_o(pin_oe_o)
    );

    task automatic step(input int tag, input logic m, input logic f, input logic w,
                        input logic [1:0] md, input logic p, input logic pd, input logic dir);
        exp_t e;
        @(negedge clk);
        match_i = m; force_i = f; cfg_wr_i = w; cfg_mode_i = md;
        pwm_mode_i = p; port_data_i = pd; port_dir_i = dir;
        if (m || (f && !p)) begin
            case (mode_m)
                2'b01: st_m = ~st_m;
                2'b10: st_m = 1'b0;
                2'b11: st_m = 1'b1;
                default: st_m = st_m;
            endcase
        end
        if (w) mode_m = md;
        e.tag = tag; e.st = st_m; e.flag = m; e.oe = dir;
        e.pin = (mode_m != 2'b00) ? st_m : pd;
        q.push_back(e);
        @(posedge clk);
    endtask

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (cmp_state_o !== e.st || pin_o !== e.pin || pin_oe_o !== e.oe ||
                match_flag_o !== e.flag) begin
                errors++;
                $display("FAIL R%0d: st/pin/oe/flag got %b%b%b%b expected %b%b%b%b",
                         e.tag, cmp_state_o, pin_o, pin_oe_o, match_flag_o,
                         e.st, e.pin, e.oe, e.flag);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        port_data_i = 1; port_dir_i = 1;
        repeat (3) @(posedge clk);
        #2;
        checks++; // R1 reset state
        if (cmp_state_o !== 0 || match_flag_o !== 0 || pin_o !== 1 || pin_oe_o !== 1) begin
            errors++;
            $display("FAIL R1: st/flag/pin/oe got %b%b%b%b expected 0011",
                     cmp_state_o, match_flag_o, pin_o, pin_oe_o);
        end
        @(negedge clk); rst_n = 1;
        // R4 / R11: match with mode off, flag pulses, state held
        step(4, 1, 0, 0, 2'b00, 0, 1, 1);
        step(11, 0, 0, 0, 2'b00, 0, 0, 1);
        // R10: write toggle with a same-cycle match (old mode applies)
        step(10, 1, 0, 1, 2'b01, 0, 0, 1);
        // R2: toggles under new mode
        step(2, 1, 0, 0, 2'b01, 0, 0, 1);
        step(2, 1, 0, 0, 2'b01, 0, 1, 1);
        step(8, 0, 0, 0, 2'b01, 0, 1, 1);
        // R3: set then clear
        step(3, 0, 0, 1, 2'b11, 0, 0, 1);
        step(3, 1, 0, 0, 2'b11, 0, 0, 1);
        step(3, 0, 0, 1, 2'b10, 0, 1, 1);
        step(3, 1, 0, 0, 2'b10, 0, 1, 1);
        // R5: force toggles without flag
        step(5, 0, 0, 1, 2'b01, 0, 0, 1);
        step(5, 0, 1, 0, 2'b01, 0, 0, 1);
        // R6 / R12: PWM mode ignores force, flag changes keep state
        step(12, 0, 0, 0, 2'b01, 1, 0, 1);
        step(6, 0, 1, 0, 2'b01, 1, 0, 1);
        step(12, 0, 0, 0, 2'b01, 0, 0, 1);
        step(12, 0, 0, 0, 2'b01, 1, 0, 1);
        // R7: force plus match toggles once
        step(7, 1, 1, 0, 2'b01, 0, 0, 1);
        step(7, 1, 1, 0, 2'b01, 0, 0, 1);
        // R13: preset while input, then enable
        step(13, 0, 0, 1, 2'b11, 0, 0, 0);
        step(13, 0, 1, 0, 2'b11, 0, 0, 0);
        step(13, 0, 0, 0, 2'b11, 0, 0, 1);
        // R8 / R9: back to port control, pin follows data, oe follows dir
        step(8, 0, 0, 1, 2'b00, 0, 0, 1);
        step(8, 0, 0, 0, 2'b00, 0, 1, 1);
        step(9, 0, 0, 0, 2'b00, 0, 1, 0);
        step(9, 0, 0, 1, 2'b10, 0, 0, 0);
        step(9, 0, 0, 0, 2'b10, 0, 1, 1);
        step(11, 0, 0, 0, 2'b10, 0, 1, 1);
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule